// File: doc/BRIEF.md
# Dual-ALU Operand Bypass Network

This block is the execute end of an integer pipeline with two fast ALU slots. Every cycle each slot may accept one issued micro-operation with an opcode, two source register tags and a destination tag. Both source values are read from a 16-entry register file in the issue cycle. One cycle later the operation executes, and each operand is taken from the newest value for its register: a fast-ALU result from the previous cycle, a delayed result from the slow producer port, or the register file value.

Each ALU result appears on the execute outputs. At the end of that same cycle it is written to the register file and captured for forwarding, so a dependent operation in either slot can execute in the very next cycle. A separate slow-result port stands in for every producer other than the two fast ALUs. Its results are written to the register file one cycle after they are presented and can be forwarded only from then on. Zero and sign flags for each slot are registered in a stage that follows execute.

Top module: `exec_pair_fwd`

## Requirements
- R1: An operation issued in cycle N shows `ex_valid`, its destination tag and its result on the execute outputs in cycle N+1. The opcode encodings are 0 add, 1 subtract (a minus b), 2 and, 3 or, 4 xor. Codes 5 to 7 give a result of zero.
- R2: A fast-ALU result is written to the register file at the end of its execute cycle. Any operation issued two or more cycles after the producer was issued reads the value from the register file.
- R3: An operation issued in the cycle right after its producer, in either slot, receives the producer's result with no stall. This holds from slot 0 to slot 1, from slot 1 to slot 0 and within one slot.
- R4: Two operations issued in the same cycle do not see each other's results. Each sees the value its source held before that cycle.
- R5: When both slots write the same destination in one cycle, the slot 1 result is the one forwarded to the next cycle's consumers and the one kept in the register file.
- R6: A slow result presented in cycle N is not seen by an operation issued in cycle N. An operation issued in cycle N+1 receives it by forwarding, and an operation issued in cycle N+2 or later reads it from the register file.
- R7: When one source tag matches several producers, operand selection prefers the fast-ALU forward, then the delayed slow forward, then the register file. When a fast ALU and the slow port write the same register at the same edge, the ALU value is kept.
- R8: In the cycle after a slot's execute result, `flg_valid` for that slot follows that slot's `ex_valid`. `flg_zero` is set exactly when the result was zero, and `flg_sign` equals result bit 31. With no operation executing, `flg_valid` is low in the following cycle.
- R9: A synchronous active-low reset clears every register-file entry to zero and clears the execute, forwarding, slow and flag valid bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| iss_valid | input | 2 | Issue valid, one bit per slot |
| iss_op | input | 2x3 | Opcode per slot |
| iss_src_a | input | 2x4 | First source tag per slot |
| iss_src_b | input | 2x4 | Second source tag per slot |
| iss_dst | input | 2x4 | Destination tag per slot |
| slow_valid | input | 1 | Slow producer result valid |
| slow_dst | input | 4 | Slow producer destination tag |
| slow_data | input | 32 | Slow producer result value |
| ex_valid | output | 2 | Execute result valid per slot |
| ex_dst | output | 2x4 | Execute destination tag per slot |
| ex_data | output | 2x32 | Execute result per slot |
| flg_valid | output | 2 | Flag stage valid per slot |
| flg_zero | output | 2 | Result was zero, per slot |
| flg_sign | output | 2 | Result bit 31, per slot |

## Verification
The hardest situation to reach from the ports is a source tag that matches a fast-ALU forward and a delayed slow forward in the same cycle, while the register file still holds an older value for that tag. The stimulus presents a slow result for a register and, in the same cycle, issues a slot 1 operation that writes the same register. One cycle later it issues a consumer of that register. The consumer therefore sees both forwarding paths live together with a stale register-file read. A final read after the writes have settled shows which value the register file kept.

// File: rtl/fwd_pkg.sv
// fwd_pkg: shared constants and opcode type for the dual-ALU execute cluster.
// Assumes two issue slots and a 3-bit opcode field.
package fwd_pkg;
    localparam int NSLOT = 2;
    localparam int OP_W  = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4
    } opcode_e;
endpackage

// File: rtl/fwd_regfile.sv
// fwd_regfile: multi-port register file with combinational reads and
// synchronous writes. When several write ports target one entry at the same
// edge, the highest-numbered port wins. Reset clears every entry to zero.
module fwd_regfile #(
    parameter int NREG = 16,
    parameter int DW   = 32,
    parameter int NRD  = 4,
    parameter int NWR  = 3,
    localparam int TAGW = $clog2(NREG)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NRD-1:0][TAGW-1:0]  rd_addr,
    output logic [NRD-1:0][DW-1:0]    rd_data,
    input  logic [NWR-1:0]            wr_en,
    input  logic [NWR-1:0][TAGW-1:0]  wr_addr,
    input  logic [NWR-1:0][DW-1:0]    wr_data
);
    logic [DW-1:0] mem [NREG];

    // Write ports applied in ascending order so the last port takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NREG; r++) mem[r] <= '0;
        end else begin
            for (int w = 0; w < NWR; w++) begin
                if (wr_en[w]) mem[wr_addr[w]] <= wr_data[w];
            end
        end
    end

    // Asynchronous read of every read port.
    always_comb begin
        for (int p = 0; p < NRD; p++) rd_data[p] = mem[rd_addr[p]];
    end
endmodule

// File: rtl/fwd_opsel.sv
// fwd_opsel: picks one source operand for an executing operation.
// Priority: fast-ALU forward (highest slot first), delayed slow forward,
// then the value read from the register file at issue time.
module fwd_opsel #(
    parameter int NSLOT = 2,
    parameter int DW    = 32,
    parameter int TAGW  = 4
) (
    input  logic [TAGW-1:0]              src_tag,
    input  logic [DW-1:0]                rf_val,
    input  logic [NSLOT-1:0]             fb_valid,
    input  logic [NSLOT-1:0][TAGW-1:0]   fb_dst,
    input  logic [NSLOT-1:0][DW-1:0]     fb_data,
    input  logic                         sv_valid,
    input  logic [TAGW-1:0]              sv_dst,
    input  logic [DW-1:0]                sv_data,
    output logic [DW-1:0]                opnd
);
    // Later assignments override earlier ones, giving the stated priority.
    always_comb begin
        opnd = rf_val;
        if (sv_valid && sv_dst == src_tag) opnd = sv_data;
        for (int k = 0; k < NSLOT; k++) begin
            if (fb_valid[k] && fb_dst[k] == src_tag) opnd = fb_data[k];
        end
    end
endmodule

// File: rtl/fwd_alu.sv
// fwd_alu: single-cycle integer ALU. Undefined opcodes produce zero.
module fwd_alu
    import fwd_pkg::*;
#(
    parameter int DW = 32
) (
    input  opcode_e         op,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    output logic [DW-1:0]   y
);
    // Opcode decode and arithmetic.
    always_comb begin
        case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/fwd_flags.sv
// fwd_flags: registers zero and sign flags for each slot one cycle after
// execute. Assumes the incoming result is stable for the whole cycle.
module fwd_flags #(
    parameter int NSLOT = 2,
    parameter int DW    = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NSLOT-1:0]            in_valid,
    input  logic [NSLOT-1:0][DW-1:0]    in_data,
    output logic [NSLOT-1:0]            flg_valid,
    output logic [NSLOT-1:0]            flg_zero,
    output logic [NSLOT-1:0]            flg_sign
);
    // Flag stage register per slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flg_valid <= '0;
            flg_zero  <= '0;
            flg_sign  <= '0;
        end else begin
            flg_valid <= in_valid;
            for (int s = 0; s < NSLOT; s++) begin
                flg_zero[s] <= (in_data[s] == '0);
                flg_sign[s] <= in_data[s][DW-1];
            end
        end
    end
endmodule

// File: rtl/exec_pair_fwd.sv
// exec_pair_fwd: two-slot execute cluster with register file, zero-latency
// forwarding between the fast ALUs, a one-cycle-delayed slow result path
// and a trailing flag stage. Assumes an external scheduler has resolved
// structural hazards; the block never stalls.
module exec_pair_fwd
    import fwd_pkg::*;
#(
    parameter int NREG = 16,
    parameter int DW   = 32,
    localparam int TAGW = $clog2(NREG)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NSLOT-1:0]              iss_valid,
    input  logic [NSLOT-1:0][OP_W-1:0]    iss_op,
    input  logic [NSLOT-1:0][TAGW-1:0]    iss_src_a,
    input  logic [NSLOT-1:0][TAGW-1:0]    iss_src_b,
    input  logic [NSLOT-1:0][TAGW-1:0]    iss_dst,
    input  logic                          slow_valid,
    input  logic [TAGW-1:0]               slow_dst,
    input  logic [DW-1:0]                 slow_data,
    output logic [NSLOT-1:0]              ex_valid,
    output logic [NSLOT-1:0][TAGW-1:0]    ex_dst,
    output logic [NSLOT-1:0][DW-1:0]      ex_data,
    output logic [NSLOT-1:0]              flg_valid,
    output logic [NSLOT-1:0]              flg_zero,
    output logic [NSLOT-1:0]              flg_sign
);
    localparam int NRD = 2 * NSLOT;
    localparam int NWR = NSLOT + 1;

    // Register file connections
    logic [NRD-1:0][TAGW-1:0]   rd_addr;
    logic [NRD-1:0][DW-1:0]     rd_data;
    logic [NWR-1:0]             wr_en;
    logic [NWR-1:0][TAGW-1:0]   wr_addr;
    logic [NWR-1:0][DW-1:0]     wr_data;

    // Execute stage state
    logic [NSLOT-1:0]           ex_v_q;
    opcode_e                    ex_op_q [NSLOT];
    logic [NSLOT-1:0][TAGW-1:0] ex_sa_q;
    logic [NSLOT-1:0][TAGW-1:0] ex_sb_q;
    logic [NSLOT-1:0][TAGW-1:0] ex_dst_q;
    logic [NSLOT-1:0][DW-1:0]   ex_ra_q;
    logic [NSLOT-1:0][DW-1:0]   ex_rb_q;
    logic [NSLOT-1:0][DW-1:0]   opnd_a;
    logic [NSLOT-1:0][DW-1:0]   opnd_b;
    logic [NSLOT-1:0][DW-1:0]   alu_y;

    // Fast forwarding registers
    logic [NSLOT-1:0]           fb_v_q;
    logic [NSLOT-1:0][TAGW-1:0] fb_dst_q;
    logic [NSLOT-1:0][DW-1:0]   fb_data_q;

    // Slow producer pipeline: stage 1 writes the file, stage 2 forwards
    logic                       s1_v_q, s2_v_q;
    logic [TAGW-1:0]            s1_dst_q, s2_dst_q;
    logic [DW-1:0]              s1_data_q, s2_data_q;

    // Read-port mapping: two ports per slot, first source then second.
    always_comb begin
        for (int s = 0; s < NSLOT; s++) begin
            rd_addr[2*s]     = iss_src_a[s];
            rd_addr[2*s + 1] = iss_src_b[s];
        end
    end

    // Write-port mapping: slow port lowest priority, then slots in order.
    always_comb begin
        wr_en[0]   = s1_v_q;
        wr_addr[0] = s1_dst_q;
        wr_data[0] = s1_data_q;
        for (int s = 0; s < NSLOT; s++) begin
            wr_en[s+1]   = ex_v_q[s];
            wr_addr[s+1] = ex_dst_q[s];
            wr_data[s+1] = alu_y[s];
        end
    end

    fwd_regfile #(
        .NREG (NREG),
        .DW   (DW),
        .NRD  (NRD),
        .NWR  (NWR)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    // Issue-to-execute pipeline register with register-file read values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex_v_q   <= '0;
            ex_sa_q  <= '0;
            ex_sb_q  <= '0;
            ex_dst_q <= '0;
            ex_ra_q  <= '0;
            ex_rb_q  <= '0;
            for (int s = 0; s < NSLOT; s++) ex_op_q[s] <= OP_ADD;
        end else begin
            ex_v_q   <= iss_valid;
            ex_sa_q  <= iss_src_a;
            ex_sb_q  <= iss_src_b;
            ex_dst_q <= iss_dst;
            for (int s = 0; s < NSLOT; s++) begin
                ex_op_q[s] <= opcode_e'(iss_op[s]);
                ex_ra_q[s] <= rd_data[2*s];
                ex_rb_q[s] <= rd_data[2*s + 1];
            end
        end
    end

    // Per-slot operand selection and ALU.
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        fwd_opsel #(
            .NSLOT (NSLOT),
            .DW    (DW),
            .TAGW  (TAGW)
        ) u_sel_a (
            .src_tag  (ex_sa_q[g]),
            .rf_val   (ex_ra_q[g]),
            .fb_valid (fb_v_q),
            .fb_dst   (fb_dst_q),
            .fb_data  (fb_data_q),
            .sv_valid (s2_v_q),
            .sv_dst   (s2_dst_q),
            .sv_data  (s2_data_q),
            .opnd     (opnd_a[g])
        );

        fwd_opsel #(
            .NSLOT (NSLOT),
            .DW    (DW),
            .TAGW  (TAGW)
        ) u_sel_b (
            .src_tag  (ex_sb_q[g]),
            .rf_val   (ex_rb_q[g]),
            .fb_valid (fb_v_q),
            .fb_dst   (fb_dst_q),
            .fb_data  (fb_data_q),
            .sv_valid (s2_v_q),
            .sv_dst   (s2_dst_q),
            .sv_data  (s2_data_q),
            .opnd     (opnd_b[g])
        );

        fwd_alu #(
            .DW (DW)
        ) u_alu (
            .op (ex_op_q[g]),
            .a  (opnd_a[g]),
            .b  (opnd_b[g]),
            .y  (alu_y[g])
        );
    end

    // Capture execute results for next-cycle forwarding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fb_v_q    <= '0;
            fb_dst_q  <= '0;
            fb_data_q <= '0;
        end else begin
            fb_v_q    <= ex_v_q;
            fb_dst_q  <= ex_dst_q;
            fb_data_q <= alu_y;
        end
    end

    // Two-stage slow result pipeline that imposes the forwarding penalty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v_q    <= 1'b0;
            s1_dst_q  <= '0;
            s1_data_q <= '0;
            s2_v_q    <= 1'b0;
            s2_dst_q  <= '0;
            s2_data_q <= '0;
        end else begin
            s1_v_q    <= slow_valid;
            s1_dst_q  <= slow_dst;
            s1_data_q <= slow_data;
            s2_v_q    <= s1_v_q;
            s2_dst_q  <= s1_dst_q;
            s2_data_q <= s1_data_q;
        end
    end

    fwd_flags #(
        .NSLOT (NSLOT),
        .DW    (DW)
    ) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (ex_v_q),
        .in_data   (alu_y),
        .flg_valid (flg_valid),
        .flg_zero  (flg_zero),
        .flg_sign  (flg_sign)
    );

    assign ex_valid = ex_v_q;
    assign ex_dst   = ex_dst_q;
    assign ex_data  = alu_y;
endmodule

// File: rtl/fwd_checker.sv
// fwd_checker: temporal properties of exec_pair_fwd, bound into every
// instance of it. Observes ports plus the executing source tags and the
// selected first operands.
module fwd_checker #(
    parameter int NSLOT = 2,
    parameter int DW    = 32,
    parameter int TAGW  = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NSLOT-1:0]            iss_valid,
    input  logic [NSLOT-1:0][TAGW-1:0]  iss_dst,
    input  logic [NSLOT-1:0]            ex_valid,
    input  logic [NSLOT-1:0][TAGW-1:0]  ex_dst,
    input  logic [NSLOT-1:0][DW-1:0]    ex_data,
    input  logic [NSLOT-1:0][TAGW-1:0]  ex_sa,
    input  logic [NSLOT-1:0][DW-1:0]    opnd_a,
    input  logic [NSLOT-1:0]            flg_valid,
    input  logic [NSLOT-1:0]            flg_zero,
    input  logic [NSLOT-1:0]            flg_sign
);
    for (genvar g = 0; g < NSLOT; g++) begin : g_chk
        // R1: an issued operation reaches execute one cycle later
        a_r1_issue_to_ex: assert property (@(posedge clk) disable iff (!rst_n)
            iss_valid[g] |=> (ex_valid[g] && ex_dst[g] == $past(iss_dst[g])));

        // R3, R5: a slot 1 result feeds the next cycle's consumer directly
        a_r3_fwd_from_slot1: assert property (@(posedge clk) disable iff (!rst_n)
            (ex_valid[g] && $past(ex_valid[1]) && ex_sa[g] == $past(ex_dst[1]))
            |-> opnd_a[g] == $past(ex_data[1]));

        // R3: a slot 0 result feeds the next consumer unless slot 1 overrode it
        a_r3_fwd_from_slot0: assert property (@(posedge clk) disable iff (!rst_n)
            (ex_valid[g] && $past(ex_valid[0]) && ex_sa[g] == $past(ex_dst[0])
             && !($past(ex_valid[1]) && $past(ex_dst[1]) == $past(ex_dst[0])))
            |-> opnd_a[g] == $past(ex_data[0]));

        // R8: flag valid follows execute valid by one cycle
        a_r8_flag_valid: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> flg_valid[g] == $past(ex_valid[g]));

        // R8: zero flag reflects a zero result
        a_r8_flag_zero: assert property (@(posedge clk) disable iff (!rst_n)
            ex_valid[g] |=> flg_zero[g] == ($past(ex_data[g]) == '0));

        // R8: sign flag is the top result bit
        a_r8_flag_sign: assert property (@(posedge clk) disable iff (!rst_n)
            ex_valid[g] |=> flg_sign[g] == $past(ex_data[g][DW-1]));
    end
endmodule

bind exec_pair_fwd fwd_checker #(
    .NSLOT (fwd_pkg::NSLOT),
    .DW    (DW),
    .TAGW  (TAGW)
) u_fwd_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_valid (iss_valid),
    .iss_dst   (iss_dst),
    .ex_valid  (ex_valid),
    .ex_dst    (ex_dst),
    .ex_data   (ex_data),
    .ex_sa     (ex_sa_q),
    .opnd_a    (opnd_a),
    .flg_valid (flg_valid),
    .flg_zero  (flg_zero),
    .flg_sign  (flg_sign)
);

// File: tb/tb_exec_pair_fwd.sv
`timescale 1ns/1ps
// tb_exec_pair_fwd: directed bench, one task per scenario.
module tb_exec_pair_fwd;
    localparam int CLK_HALF = 10;
    localparam logic [2:0] K_ADD = 3'd0, K_SUB = 3'd1, K_AND = 3'd2,
                           K_OR = 3'd3, K_XOR = 3'd4, K_BAD = 3'd7;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [1:0]       iss_valid;
    logic [1:0][2:0]  iss_op;
    logic [1:0][3:0]  iss_src_a, iss_src_b, iss_dst;
    logic             slow_valid;
    logic [3:0]       slow_dst;
    logic [31:0]      slow_data;
    logic [1:0]       ex_valid;
    logic [1:0][3:0]  ex_dst;
    logic [1:0][31:0] ex_data;
    logic [1:0]       flg_valid, flg_zero, flg_sign;

    int n_checks = 0;
    int n_fail   = 0;

    always #CLK_HALF clk = ~clk;

    exec_pair_fwd dut (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_src_a(iss_src_a), .iss_src_b(iss_src_b), .iss_dst(iss_dst),
        .slow_valid(slow_valid), .slow_dst(slow_dst), .slow_data(slow_data),
        .ex_valid(ex_valid), .ex_dst(ex_dst), .ex_data(ex_data),
        .flg_valid(flg_valid), .flg_zero(flg_zero), .flg_sign(flg_sign)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_inputs();
        iss_valid = '0; iss_op = '0; iss_src_a = '0; iss_src_b = '0; iss_dst = '0;
        slow_valid = 1'b0; slow_dst = '0; slow_data = '0;
    endtask

    // One clock: inputs set before the edge, outputs sampled at the next negedge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_uop(input int s, input logic [2:0] op, input logic [3:0] a,
                           input logic [3:0] b, input logic [3:0] d);
        iss_valid[s] = 1'b1; iss_op[s] = op;
        iss_src_a[s] = a; iss_src_b[s] = b; iss_dst[s] = d;
    endtask

    task automatic slow_load(input logic [3:0] r, input logic [31:0] v);
        slow_valid = 1'b1; slow_dst = r; slow_data = v;
        step();
        clear_inputs();
        step();
        step();
    endtask

    task automatic read_reg(input logic [3:0] r, output logic [31:0] v);
        set_uop(0, K_OR, r, r, r);
        step();
        v = ex_data[0];
        clear_inputs();
        step();
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R9 ex_valid after reset", {30'd0, ex_valid}, 32'd0);
        check("R9 flg_valid after reset", {30'd0, flg_valid}, 32'd0);
        read_reg(4'd5, v);
        check("R9 register cleared", v, 32'd0);
    endtask

    task automatic t_ops();
        logic [2:0]  ops [6] = '{K_ADD, K_SUB, K_AND, K_OR, K_XOR, K_BAD};
        logic [31:0] exp [6] = '{32'h0000_0FFF, 32'hFFFF_F1E1, 32'h0, 32'h0000_0FFF,
                                 32'h0000_0FFF, 32'h0};
        for (int i = 0; i < 6; i++) begin
            set_uop(0, ops[i], 4'd1, 4'd2, 4'd11);
            set_uop(1, ops[i], 4'd1, 4'd2, 4'd10);
            step();
            check("R1 slot0 result", ex_data[0], exp[i]);
            check("R1 slot1 result", ex_data[1], exp[i]);
            if (i == 0) begin
                check("R1 ex_valid", {30'd0, ex_valid}, 32'd3);
                check("R1 ex_dst slot1", {28'd0, ex_dst[1]}, 32'd10);
            end
            clear_inputs();
        end
        step();
    endtask

    task automatic t_flags();
        set_uop(0, K_AND, 4'd1, 4'd2, 4'd11);
        set_uop(1, K_SUB, 4'd1, 4'd2, 4'd10);
        step();
        clear_inputs();
        step();
        check("R8 flg_valid", {30'd0, flg_valid}, 32'd3);
        check("R8 zero slot0", {31'd0, flg_zero[0]}, 32'd1);
        check("R8 sign slot0", {31'd0, flg_sign[0]}, 32'd0);
        check("R8 zero slot1", {31'd0, flg_zero[1]}, 32'd0);
        check("R8 sign slot1", {31'd0, flg_sign[1]}, 32'd1);
        step();
        check("R8 flg_valid idle", {30'd0, flg_valid}, 32'd0);
    endtask

    task automatic t_back_to_back();
        set_uop(0, K_ADD, 4'd1, 4'd2, 4'd3);
        step();
        clear_inputs();
        set_uop(1, K_ADD, 4'd3, 4'd1, 4'd4);
        step();
        check("R3 slot0 to slot1", ex_data[1], 32'h0000_10EF);
        clear_inputs();
        set_uop(0, K_XOR, 4'd4, 4'd2, 4'd5);
        step();
        check("R3 slot1 to slot0", ex_data[0], 32'h0000_1FE0);
        clear_inputs();
        set_uop(0, K_ADD, 4'd3, 4'd5, 4'd6);
        step();
        check("R2 file plus R3 same slot", ex_data[0], 32'h0000_2FDF);
        clear_inputs();
        step();
    endtask

    task automatic t_same_cycle();
        logic [31:0] v;
        set_uop(0, K_ADD, 4'd1, 4'd2, 4'd12);
        set_uop(1, K_OR, 4'd12, 4'd12, 4'd13);
        step();
        check("R4 same-cycle sees old value", ex_data[1], 32'd0);
        clear_inputs();
        step();
        read_reg(4'd12, v);
        check("R2 value kept in file", v, 32'h0000_0FFF);
    endtask

    task automatic t_dual_dst();
        logic [31:0] v;
        set_uop(0, K_ADD, 4'd1, 4'd1, 4'd7);
        set_uop(1, K_ADD, 4'd2, 4'd2, 4'd7);
        step();
        clear_inputs();
        set_uop(0, K_OR, 4'd7, 4'd7, 4'd8);
        step();
        check("R5 forward picks slot1", ex_data[0], 32'h0000_1E1E);
        clear_inputs();
        step();
        read_reg(4'd7, v);
        check("R5 file keeps slot1", v, 32'h0000_1E1E);
    endtask

    task automatic t_slow();
        slow_valid = 1'b1; slow_dst = 4'd14; slow_data = 32'hCAFE_0001;
        set_uop(0, K_OR, 4'd14, 4'd14, 4'd15);
        step();
        check("R6 no forward in same cycle", ex_data[0], 32'd0);
        clear_inputs();
        set_uop(0, K_OR, 4'd14, 4'd14, 4'd15);
        step();
        check("R6 delayed forward", ex_data[0], 32'hCAFE_0001);
        set_uop(0, K_OR, 4'd14, 4'd14, 4'd15);
        step();
        check("R6 from register file", ex_data[0], 32'hCAFE_0001);
        clear_inputs();
        step();
    endtask

    task automatic t_priority();
        logic [31:0] v;
        slow_valid = 1'b1; slow_dst = 4'd9; slow_data = 32'h5555_0000;
        set_uop(1, K_ADD, 4'd1, 4'd2, 4'd9);
        step();
        clear_inputs();
        set_uop(0, K_OR, 4'd9, 4'd9, 4'd13);
        step();
        check("R7 fast beats slow forward", ex_data[0], 32'h0000_0FFF);
        clear_inputs();
        step();
        read_reg(4'd9, v);
        check("R7 ALU write beats slow write", v, 32'h0000_0FFF);
    endtask

    initial begin
        #(200000 * 2 * CLK_HALF);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        clear_inputs();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        slow_load(4'd1, 32'h0000_00F0);
        slow_load(4'd2, 32'h0000_0F0F);
        t_ops();
        t_flags();
        t_back_to_back();
        t_same_cycle();
        t_dual_dst();
        t_slow();
        t_priority();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule